// File: doc/BRIEF.md
# Byte/Word Mailbox FIFO Interface

This block is a mailbox that sits on a simple register port. Software pushes bytes into a transmit queue and pulls bytes from a receive queue. Each queue entry is a data byte plus a command marker bit. Each direction can be set, independently, to move one byte or one 32-bit word per register access. The ready flags in the status register always describe whether one whole unit of the selected size can be moved.

On the far side, the block exchanges a plain byte stream with a marker bit, using valid/ready handshakes. Out of reset the block is in loopback: transmit bytes go straight into the receive queue, and the external stream stays idle. Software can start a flush that empties both queues over a fixed number of cycles. It can also clear two sticky status flags by writing ones to them.

Register map, selected by a 3-bit address: 0 control, 1 status, 2 transmit data, 3 transmit command, 4 receive data. Control bits: [0] enable, [1] loopback, [2] transmit word mode, [3] receive word mode, [4] flush start (reads as 1 while a flush runs), [5] flush in progress (read-only). Status bits: [0] receive ready, [1] transmit ready, [2] receive empty, [3] receive full, [4] transmit empty, [5] transmit full, [6] head command marker, [7] link flush seen (write 1 to clear), [8] transfer error (write 1 to clear).

Top module: `mbox_fifo_if`

## Requirements
- R1: After reset, control reads 0x02 (loopback on, everything else 0) and status reads 0x16 (transmit ready, both queues empty).
- R2: While control bit [0] is 0, writes to transmit data or transmit command leave the transmit queue unchanged and set status bit [8].
- R3: Transmit ready (status [1]) is 1 exactly when the free space is at least one unit: 1 byte, or 4 bytes when control [2] is 1. A write made without room is dropped, sets status [8], and never overfills the queue.
- R4: Receive ready (status [0]) is 1 when at least 1 byte is queued, or at least 4 when control [3] is 1. A receive data read removes one unit. A read without a full unit returns 0, removes nothing, and sets status [8].
- R5: Words are little-endian. Bits [7:0] of a word write are queued first, and the oldest received byte is returned in bits [7:0] of a word read.
- R6: Writing control with bit [4] = 1 starts a flush. Control bits [4] and [5] then read 1 for exactly 4 cycles and return to 0 by themselves. Writing bit [4] = 0 starts nothing.
- R7: During a flush, data writes are ignored, receive data reads return 0 and remove nothing, and the external stream is idle. Once the flush ends, both queues are empty.
- R8: Status [6] equals the marker of the byte at the head of the receive queue, and is 0 when the queue is empty. A transmit command write marks its first byte only.
- R9: Status [7] is set by a pulse on the link flush input, and status [8] is set by a failed access. Each stays set until status is written with a 1 in that bit.
- R10: With loopback on, one transmit byte per cycle moves into the receive queue, marker included, whenever the receive queue has room. The external valid and ready outputs stay 0.
- R11: With loopback off, transmit bytes leave in order on the external output under valid/ready. External receive bytes are accepted whenever the receive queue has room.
- R12: Empty and full status bits follow the queue levels without any software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the receive queue at receive data) |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from address |
| txOutValid | output | 1 | Outgoing byte valid |
| txOutReady | input | 1 | Far side accepts outgoing byte |
| txOutByte | output | 8 | Outgoing byte |
| txOutMark | output | 1 | Outgoing command marker |
| rxInValid | input | 1 | Incoming byte valid |
| rxInReady | output | 1 | Block accepts incoming byte |
| rxInByte | input | 8 | Incoming byte |
| rxInMark | input | 1 | Incoming command marker |
| linkFlushIn | input | 1 | Flush notification from the far side |

## Verification
Some properties are checked on every cycle. The external stream must stay silent in loopback and during a flush. A flush must never last longer than its window, and a flush must follow every flush-starting write. The queues must be empty when a flush ends, and neither level may exceed the depth. The sticky flags may fall only on a write-one-to-clear. The bench's scenarios show what a property cannot see on its own: little-endian byte order in both directions, how the ready flags switch when the unit size changes at a given level, the head marker moving as bytes are popped, the exact cycle on which loopback fills a word, and the value returned by rejected reads.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BYTE_W = 8;
  localparam int ENTRY_W = BYTE_W + 1;
  localparam int WORD_LANES = 4;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXDATA = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXCMD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXDATA = 3'd4;

  localparam int C_ENABLE = 0;
  localparam int C_LOOP   = 1;
  localparam int C_TXWORD = 2;
  localparam int C_RXWORD = 3;
  localparam int C_FLUSH  = 4;

  localparam int S_FLUSHSEEN = 7;
  localparam int S_XFERERR   = 8;

  typedef struct packed {
    logic        txPush;
    logic        txWord;
    logic        txMark;
    logic        rxPop;
    logic        rxWord;
    logic        clear;
    logic        loopback;
    logic [31:0] txData;
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_byte_fifo.sv
module mbox_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int PUSH_LANES = 1,
  parameter int POP_LANES = 1,
  parameter int ENTRY_W = 9,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = PW + 1,
  localparam int PCW = $clog2(PUSH_LANES + 1),
  localparam int QCW = $clog2(POP_LANES + 1)
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  clear,
  input  logic [PCW-1:0]                        pushCnt,
  input  logic [PUSH_LANES-1:0][ENTRY_W-1:0]    pushData,
  input  logic [QCW-1:0]                        popCnt,
  output logic [POP_LANES-1:0][ENTRY_W-2:0]     peekBytes,
  output logic                                  headMark,
  output logic [LW-1:0]                         level
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  // storage: up to PUSH_LANES consecutive entries per cycle
  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_LANES; i++) begin
      if (PCW'(i) < pushCnt) mem[wrPtr + PW'(i)] <= pushData[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + PW'(pushCnt);
      rdPtr <= rdPtr + PW'(popCnt);
      level <= level + LW'(pushCnt) - LW'(popCnt);
    end
  end

  for (genvar g = 0; g < POP_LANES; g++) begin : g_peek
    assign peekBytes[g] = mem[rdPtr + PW'(g)][ENTRY_W-2:0];
  end
  assign headMark = mem[rdPtr][ENTRY_W-1];
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  mboxStrobes_t strb,
  input  logic         txOutReady,
  output logic         txOutValid,
  output logic [7:0]   txOutByte,
  output logic         txOutMark,
  input  logic         rxInValid,
  input  logic [7:0]   rxInByte,
  input  logic         rxInMark,
  output logic         rxInReady,
  output logic [LW-1:0] txLevel,
  output logic [LW-1:0] rxLevel,
  output logic         rxHeadMark,
  output logic [31:0]  rxPeekWord
);
  logic [2:0] txPushCnt, rxPopCnt;
  logic [WORD_LANES-1:0][ENTRY_W-1:0] txPushData;
  logic [0:0][BYTE_W-1:0] txHeadByte;
  logic txHeadMark;
  logic txPopCnt, rxPushCnt;
  logic [0:0][ENTRY_W-1:0] rxPushData;
  logic [WORD_LANES-1:0][BYTE_W-1:0] rxPeek;
  logic txHasData, rxHasRoom, lbMove, linkTxFire, linkRxFire;

  // transmit side: one byte or four bytes enter per cycle
  assign txPushCnt = strb.txPush ? (strb.txWord ? 3'd4 : 3'd1) : 3'd0;
  for (genvar g = 0; g < WORD_LANES; g++) begin : g_txLane
    assign txPushData[g] = {strb.txMark & (g == 0), strb.txData[BYTE_W*g +: BYTE_W]};
  end

  assign txHasData  = (txLevel != '0);
  assign rxHasRoom  = (rxLevel != LW'(DEPTH));
  assign lbMove     = strb.loopback && !strb.clear && txHasData && rxHasRoom;
  assign txOutValid = !strb.loopback && !strb.clear && txHasData;
  assign linkTxFire = txOutValid && txOutReady;
  assign txPopCnt   = lbMove || linkTxFire;
  assign txOutByte  = txHeadByte[0];
  assign txOutMark  = txHeadMark;

  // receive side: one byte enters per cycle, from loopback or the link
  assign rxInReady  = !strb.loopback && !strb.clear && rxHasRoom;
  assign linkRxFire = rxInValid && rxInReady;
  assign rxPushCnt  = lbMove || linkRxFire;
  assign rxPushData[0] = lbMove ? {txHeadMark, txHeadByte[0]} : {rxInMark, rxInByte};
  assign rxPopCnt   = strb.rxPop ? (strb.rxWord ? 3'd4 : 3'd1) : 3'd0;

  for (genvar g = 0; g < WORD_LANES; g++) begin : g_rxLane
    assign rxPeekWord[BYTE_W*g +: BYTE_W] = rxPeek[g];
  end

  mbox_byte_fifo #(
    .DEPTH(DEPTH), .PUSH_LANES(WORD_LANES), .POP_LANES(1), .ENTRY_W(ENTRY_W)
  ) u_txFifo (
    .clk(clk), .rstN(rstN), .clear(strb.clear),
    .pushCnt(txPushCnt), .pushData(txPushData),
    .popCnt(txPopCnt), .peekBytes(txHeadByte), .headMark(txHeadMark),
    .level(txLevel)
  );

  mbox_byte_fifo #(
    .DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(WORD_LANES), .ENTRY_W(ENTRY_W)
  ) u_rxFifo (
    .clk(clk), .rstN(rstN), .clear(strb.clear),
    .pushCnt(rxPushCnt), .pushData(rxPushData),
    .popCnt(rxPopCnt), .peekBytes(rxPeek), .headMark(rxHeadMark),
    .level(rxLevel)
  );
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FLUSH_CYCLES = 4,
  localparam int LW = $clog2(DEPTH) + 1,
  localparam int FW = $clog2(FLUSH_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [LW-1:0]     txLevel,
  input  logic [LW-1:0]     rxLevel,
  input  logic              rxHeadMark,
  input  logic [31:0]       rxPeekWord,
  input  logic              linkFlushIn,
  output mboxStrobes_t      strb,
  output logic              flushBusy,
  output logic [1:0]        stickyFlags
);
  logic enable, loopback, txWord, rxWord;
  logic flushSeen, xferErr;
  logic [FW-1:0] flushCnt;
  logic wrCtrl, wrStat, wrTx, rdRx;
  logic txReady, rxReady, txAccept, rxAccept, errEvent;
  logic [LW-1:0] txUnit, rxUnit, txFree;
  logic cmdHead;

  assign wrCtrl = regWrEn && (regAddr == A_CTRL);
  assign wrStat = regWrEn && (regAddr == A_STAT);
  assign wrTx   = regWrEn && ((regAddr == A_TXDATA) || (regAddr == A_TXCMD));
  assign rdRx   = regRdEn && (regAddr == A_RXDATA);

  assign flushBusy = (flushCnt != '0);

  // unit-sized readiness
  assign txUnit  = txWord ? LW'(WORD_LANES) : LW'(1);
  assign rxUnit  = rxWord ? LW'(WORD_LANES) : LW'(1);
  assign txFree  = LW'(DEPTH) - txLevel;
  assign txReady = (txFree >= txUnit);
  assign rxReady = (rxLevel >= rxUnit);

  assign txAccept = wrTx && !flushBusy && enable && txReady;
  assign rxAccept = rdRx && !flushBusy && rxReady;
  assign errEvent = (wrTx && !flushBusy && !(enable && txReady))
                 || (rdRx && !flushBusy && !rxReady);
  assign cmdHead  = (rxLevel != '0) && rxHeadMark;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      loopback <= 1'b1;
      txWord   <= 1'b0;
      rxWord   <= 1'b0;
    end else if (wrCtrl) begin
      enable   <= regWdata[C_ENABLE];
      loopback <= regWdata[C_LOOP];
      txWord   <= regWdata[C_TXWORD];
      rxWord   <= regWdata[C_RXWORD];
    end
  end

  // fixed-length flush sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushCnt <= '0;
    end else if (wrCtrl && regWdata[C_FLUSH] && !flushBusy) begin
      flushCnt <= FW'(FLUSH_CYCLES);
    end else if (flushBusy) begin
      flushCnt <= flushCnt - FW'(1);
    end
  end

  // sticky flags: hardware set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushSeen <= 1'b0;
      xferErr   <= 1'b0;
    end else begin
      if (linkFlushIn)
        flushSeen <= 1'b1;
      else if (wrStat && regWdata[S_FLUSHSEEN])
        flushSeen <= 1'b0;
      if (errEvent)
        xferErr <= 1'b1;
      else if (wrStat && regWdata[S_XFERERR])
        xferErr <= 1'b0;
    end
  end

  assign stickyFlags = {xferErr, flushSeen};

  always_comb begin
    strb          = '0;
    strb.txPush   = txAccept;
    strb.txWord   = txWord;
    strb.txMark   = (regAddr == A_TXCMD);
    strb.rxPop    = rxAccept;
    strb.rxWord   = rxWord;
    strb.clear    = flushBusy;
    strb.loopback = loopback;
    strb.txData   = regWdata;
  end

  always_comb begin
    case (regAddr)
      A_CTRL:   regRdata = {26'd0, flushBusy, flushBusy, rxWord, txWord, loopback, enable};
      A_STAT:   regRdata = {23'd0, xferErr, flushSeen, cmdHead,
                            txLevel == LW'(DEPTH), txLevel == '0,
                            rxLevel == LW'(DEPTH), rxLevel == '0,
                            txReady, rxReady};
      A_RXDATA: begin
        if (flushBusy || !rxReady) regRdata = '0;
        else if (rxWord)           regRdata = rxPeekWord;
        else                       regRdata = {24'd0, rxPeekWord[7:0]};
      end
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/mbox_fifo_if.sv
module mbox_fifo_if
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FLUSH_CYCLES = 4,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        txOutValid,
  input  logic        txOutReady,
  output logic [7:0]  txOutByte,
  output logic        txOutMark,
  input  logic        rxInValid,
  output logic        rxInReady,
  input  logic [7:0]  rxInByte,
  input  logic        rxInMark,
  input  logic        linkFlushIn
);
  mboxStrobes_t strb;
  logic [LW-1:0] txLevel, rxLevel;
  logic rxHeadMark, flushBusy, loopbackOn;
  logic [31:0] rxPeekWord;
  logic [1:0] stickyFlags;

  assign loopbackOn = strb.loopback;

  mbox_ctrl #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txLevel(txLevel), .rxLevel(rxLevel), .rxHeadMark(rxHeadMark),
    .rxPeekWord(rxPeekWord), .linkFlushIn(linkFlushIn),
    .strb(strb), .flushBusy(flushBusy), .stickyFlags(stickyFlags)
  );

  mbox_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txOutReady(txOutReady), .txOutValid(txOutValid),
    .txOutByte(txOutByte), .txOutMark(txOutMark),
    .rxInValid(rxInValid), .rxInByte(rxInByte), .rxInMark(rxInMark),
    .rxInReady(rxInReady), .txLevel(txLevel), .rxLevel(rxLevel),
    .rxHeadMark(rxHeadMark), .rxPeekWord(rxPeekWord)
  );
endmodule

// File: rtl/mbox_fifo_if_checker.sv
module mbox_fifo_if_checker
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FLUSH_CYCLES = 4,
  localparam int LW = $clog2(DEPTH) + 1,
  localparam int RW = $clog2(FLUSH_CYCLES + 2) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrEn,
  input logic [2:0]    regAddr,
  input logic [31:0]   regWdata,
  input logic          flushBusy,
  input logic          loopbackOn,
  input logic          txOutValid,
  input logic          rxInReady,
  input logic [LW-1:0] txLevel,
  input logic [LW-1:0] rxLevel,
  input logic [1:0]    stickyFlags
);
  logic [RW-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (!flushBusy) busyRun <= '0;
    else if (busyRun != {RW{1'b1}}) busyRun <= busyRun + RW'(1);
  end

  assert_loop_link_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    loopbackOn |-> (!txOutValid && !rxInReady));

  assert_flush_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |-> (busyRun < RW'(FLUSH_CYCLES)));

  assert_flush_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_CTRL && regWdata[C_FLUSH] && !flushBusy) |=> flushBusy);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flushBusy) |-> (txLevel == '0 && rxLevel == '0));

  assert_flush_link_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |-> (!txOutValid && !rxInReady));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LW'(DEPTH)) && (rxLevel <= LW'(DEPTH)));

  assert_flushseen_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stickyFlags[0] && !(regWrEn && regAddr == A_STAT && regWdata[S_FLUSHSEEN]))
      |=> stickyFlags[0]);

  assert_xfererr_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stickyFlags[1] && !(regWrEn && regAddr == A_STAT && regWdata[S_XFERERR]))
      |=> stickyFlags[1]);
endmodule

bind mbox_fifo_if mbox_fifo_if_checker #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWdata(regWdata), .flushBusy(flushBusy), .loopbackOn(loopbackOn),
  .txOutValid(txOutValid), .rxInReady(rxInReady), .txLevel(txLevel),
  .rxLevel(rxLevel), .stickyFlags(stickyFlags)
);

// File: tb/mbox_fifo_if_bench.sv
`timescale 1ns/1ps
module mbox_fifo_if_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic txOutValid, txOutMark, rxInReady;
  logic txOutReady = 1'b0;
  logic [7:0] txOutByte;
  logic rxInValid = 1'b0, rxInMark = 1'b0, linkFlushIn = 1'b0;
  logic [7:0] rxInByte = '0;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  mbox_fifo_if u_mbox_fifo_if (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txOutValid(txOutValid), .txOutReady(txOutReady), .txOutByte(txOutByte),
    .txOutMark(txOutMark), .rxInValid(rxInValid), .rxInReady(rxInReady),
    .rxInByte(rxInByte), .rxInMark(rxInMark), .linkFlushIn(linkFlushIn)
  );

  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, TXD = 3'd2, TXC = 3'd3, RXD = 3'd4;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWrEn = 0; regRdEn = 0; txOutReady = 0; rxInValid = 0; linkFlushIn = 0;
    idle(2);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // read with the strobe (pops at receive data)
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // look at a register without a strobe
  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pushLink(input logic [7:0] b, input logic m);
    @(negedge clk);
    rxInValid = 1'b1; rxInByte = b; rxInMark = m;
    @(negedge clk);
    rxInValid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    doReset();
    peek(CTRL, v); chk("R1 control reset", v, 32'h02);
    peek(STAT, v); chk("R1 status reset", v, 32'h16);
    chk("R10 link idle in reset loopback", {30'd0, txOutValid, rxInReady}, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    doReset();
    wr(TXD, 32'h55);
    idle(3);
    peek(STAT, v);
    chk("R2 tx stays empty while disabled", {31'd0, v[4]}, 32'h1);
    chk("R2 rx stays empty while disabled", {31'd0, v[2]}, 32'h1);
    chk("R2 disabled write flags error", {31'd0, v[8]}, 32'h1);
  endtask

  task automatic t_loopback();
    logic [31:0] v;
    doReset();
    wr(CTRL, 32'h03);
    wr(TXC, 32'hA5);
    idle(3);
    peek(STAT, v); chk("R10 byte looped back, status", v, 32'h53);
    chk("R10 link idle in loopback", {30'd0, txOutValid, rxInReady}, 32'h0);
    rd(RXD, v); chk("R10 looped byte value", v, 32'hA5);
    // word mode: one byte per cycle reaches the receive side
    wr(CTRL, 32'h0F);
    wr(TXD, 32'h44332211);
    idle(3);
    peek(STAT, v); chk("R10 three bytes moved, word not ready", {31'd0, v[0]}, 32'h0);
    idle(1);
    peek(STAT, v); chk("R10 fourth byte moved, word ready", {31'd0, v[0]}, 32'h1);
    rd(RXD, v); chk("R5 word read order", v, 32'h44332211);
  endtask

  task automatic t_byteOrder();
    logic [31:0] v;
    doReset();
    wr(CTRL, 32'h07);
    wr(TXD, 32'hDDCCBBAA);
    idle(5);
    rd(RXD, v); chk("R5 first byte", v, 32'hAA);
    rd(RXD, v); chk("R5 second byte", v, 32'hBB);
    rd(RXD, v); chk("R5 third byte", v, 32'hCC);
    rd(RXD, v); chk("R5 fourth byte", v, 32'hDD);
  endtask

  task automatic t_rxShort();
    logic [31:0] v;
    doReset();
    wr(CTRL, 32'h0B);
    wr(TXD, 32'h01); wr(TXD, 32'h02); wr(TXD, 32'h03);
    idle(4);
    peek(STAT, v);
    chk("R4 three bytes, word not ready", {31'd0, v[0]}, 32'h0);
    rd(RXD, v); chk("R4 short word read returns zero", v, 32'h0);
    peek(STAT, v);
    chk("R4 short read removes nothing", {31'd0, v[2]}, 32'h0);
    chk("R9 short read sets error", {31'd0, v[8]}, 32'h1);
    wr(STAT, 32'h0);
    peek(STAT, v); chk("R9 writing zero keeps error", {31'd0, v[8]}, 32'h1);
    wr(STAT, 32'h100);
    peek(STAT, v); chk("R9 write one clears error", {31'd0, v[8]}, 32'h0);
    wr(CTRL, 32'h03);
    peek(STAT, v); chk("R4 byte mode ready with three bytes", {31'd0, v[0]}, 32'h1);
    rd(RXD, v); chk("R4 byte read", v, 32'h01);
  endtask

  task automatic t_txFull();
    logic [31:0] v;
    int got;
    logic ok;
    doReset();
    wr(CTRL, 32'h01);
    for (int i = 0; i < 13; i++) wr(TXD, 32'h10 + i);
    peek(STAT, v); chk("R3 three free, byte unit ready", {31'd0, v[1]}, 32'h1);
    wr(CTRL, 32'h05);
    peek(STAT, v); chk("R3 three free, word unit not ready", {31'd0, v[1]}, 32'h0);
    wr(TXD, 32'hEEEEEEEE);
    peek(STAT, v); chk("R3 rejected word sets error", {31'd0, v[8]}, 32'h1);
    wr(CTRL, 32'h01);
    for (int i = 13; i < 16; i++) wr(TXD, 32'h10 + i);
    peek(STAT, v);
    chk("R12 tx full flag", {31'd0, v[5]}, 32'h1);
    chk("R3 full, not ready", {31'd0, v[1]}, 32'h0);
    wr(TXD, 32'h99);
    txOutReady = 1'b1;
    got = 0; ok = 1'b1;
    for (int c = 0; c < 24; c++) begin
      #1;
      if (txOutValid) begin
        if (txOutByte !== 8'(8'h10 + got)) ok = 1'b0;
        got++;
      end
      @(negedge clk);
    end
    txOutReady = 1'b0;
    chk("R11 link bytes in order", {31'd0, ok}, 32'h1);
    chk("R3 exactly sixteen bytes left", got, 32'd16);
    peek(STAT, v); chk("R12 tx empty after drain", {31'd0, v[4]}, 32'h1);
  endtask

  task automatic t_rxLink();
    logic [31:0] v;
    doReset();
    wr(CTRL, 32'h01);
    #1 chk("R11 link receive ready", {31'd0, rxInReady}, 32'h1);
    pushLink(8'h5A, 1'b1);
    pushLink(8'h3C, 1'b0);
    peek(STAT, v); chk("R8 head marker set", {31'd0, v[6]}, 32'h1);
    rd(RXD, v); chk("R11 first link byte", v, 32'h5A);
    peek(STAT, v); chk("R8 head marker follows head", {31'd0, v[6]}, 32'h0);
    rd(RXD, v); chk("R11 second link byte", v, 32'h3C);
    for (int i = 0; i < 16; i++) pushLink(8'(i), 1'b0);
    peek(STAT, v); chk("R12 rx full flag", {31'd0, v[3]}, 32'h1);
    #1 chk("R11 full receive not ready", {31'd0, rxInReady}, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    doReset();
    wr(CTRL, 32'h03);
    wr(TXD, 32'h11); wr(TXD, 32'h22);
    idle(3);
    wr(CTRL, 32'h03);
    peek(CTRL, v); chk("R6 writing zero starts nothing", {30'd0, v[5:4]}, 32'h0);
    wr(CTRL, 32'h13);
    for (int k = 0; k < 5; k++) begin
      #1 chk($sformatf("R6 flush flags cycle %0d", k), {30'd0, regRdata[5:4]},
             (k < 4) ? 32'h3 : 32'h0);
      @(negedge clk);
    end
    peek(STAT, v); chk("R7 queues empty after flush", v, 32'h16);
    wr(TXD, 32'h33);
    idle(3);
    wr(CTRL, 32'h13);
    rd(RXD, v); chk("R7 read during flush returns zero", v, 32'h0);
    wr(TXD, 32'h44);
    idle(4);
    peek(STAT, v); chk("R7 access during flush ignored", v, 32'h16);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    doReset();
    @(negedge clk); linkFlushIn = 1'b1;
    @(negedge clk); linkFlushIn = 1'b0;
    peek(STAT, v); chk("R9 link flush seen", {31'd0, v[7]}, 32'h1);
    wr(STAT, 32'h100);
    peek(STAT, v); chk("R9 other bit write keeps flag", {31'd0, v[7]}, 32'h1);
    wr(STAT, 32'h80);
    peek(STAT, v); chk("R9 write one clears flag", {31'd0, v[7]}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_loopback();
    t_byteOrder();
    t_rxShort();
    t_txFull();
    t_rxLink();
    t_flush();
    t_sticky();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #100000;
    total++; fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule